// File: doc/BRIEF.md
# Microcoded State Sequencer with Two-Phase State Clock

This block is a table-driven controller. A 7-bit present-state register and one stored qualifier bit form an 8-bit address into a microcode table. The word read back gives the next state, an active-low select for the qualifier to test in that next state, and four control strobes. Eight external condition inputs feed an 8:1 selector, and the selector's output is the qualifier. Each cycle through the table is one step of an algorithm.

Everything runs on one fast clock. A binary divider turns that clock into a state clock of 2^DIV_LOG2 fast cycles per period, with two complementary phase outputs. The state register and the control strobes update once per period, at its last fast cycle. The qualifier is sampled half a period earlier, at the end of the first half. The table address therefore never changes close to a state update. The microcode table is a parameter that is filled at elaboration.

Top module: `asm_seq`

## Requirements
- R1: While rst_ni is low, state_o is 0, qual_o is 0, all four control strobes are 0, sclk_h_o is 1, and the qualifier select points at condition input 0.
- R2: The fast cycles are counted from reset, modulo 2^DIV_LOG2 (32 by default). sclk_h_o is 1 when the count is below half of that and 0 otherwise. sclk_l_o is always the complement of sclk_h_o.
- R3: state_o changes only at the clock edge where the count is at its last value, 2^DIV_LOG2-1.
- R4: qual_o changes only at the edge where the count equals half the period minus one. Changes on cond_i at any other time have no effect on qual_o or on the next state.
- R5: At that sampling edge, qual_o takes cond_i[k], where k is the bitwise inverse of the active-low 3-bit select held from the last microcode word.
- R6: At the update edge, the state becomes the next-state field of the word at address {qual_o, state_o}, with the qualifier as bit 7.
- R7: The control strobes oe_o, mem_out_o, xfer_en_o and close_sw_o are loaded from the same word at the same edge as the state, and they hold between updates.
- R8: The word packing is: bits [13:7] next state, [6:4] active-low qualifier select, [3] output enable, [2] memory-output strobe, [1] transfer enable, [0] close switch.
- R9: The default table sets next = (s + (q ? 1 : 3)) mod 128 and qsel_n = ~next[2:0], and sets the four strobe bits [3:0] to s[3:0] XOR {q,q,q,q}. Here s is the state and q is the qualifier of the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cond_i | input | 8 | Condition inputs for the qualifier selector |
| sclk_h_o | output | 1 | State clock, high phase |
| sclk_l_o | output | 1 | State clock, low phase (complement) |
| state_o | output | 7 | Present state (bit 0 least significant) |
| qual_o | output | 1 | Stored qualifier |
| oe_o | output | 1 | Output enable strobe |
| mem_out_o | output | 1 | Memory-output strobe |
| xfer_en_o | output | 1 | Transfer enable |
| close_sw_o | output | 1 | Close-switch control |

## Verification
A wrong divider count moves the sample and update edges, so it shows on the clock outputs at once. It also shows on state_o within one state-clock period. A wrong qualifier select or a qualifier sampled at the wrong time gives a wrong state at the next update edge. The error then spreads through every later state, because each address depends on the one before it. A bench model of the count, state, qualifier and strobes is compared with the ports on every fast cycle. Inputs are held constant low, constant high and random, and a reset is applied in the middle of a run.

// File: rtl/asm_seq_pkg.sv
package asm_seq_pkg;
  localparam int STATE_W = 7;
  localparam int QSEL_W  = 3;
  localparam int NCOND   = 2 ** QSEL_W;
  localparam int CTRL_W  = 4;
  localparam int ADDR_W  = STATE_W + 1;
  localparam int WORD_W  = STATE_W + QSEL_W + CTRL_W;
  localparam int DEPTH   = 2 ** ADDR_W;

  typedef struct packed {
    logic [STATE_W-1:0] nxt;
    logic [QSEL_W-1:0]  qsel_n;
    logic               oe;
    logic               mem_out;
    logic               xfer_en;
    logic               close_sw;
  } uword_t;

  typedef logic [DEPTH-1:0][WORD_W-1:0] ucode_t;

  // default microcode: step by 1 or 3, select follows low state bits
  function automatic ucode_t default_ucode();
    ucode_t t;
    for (int a = 0; a < DEPTH; a++) begin
      logic [ADDR_W-1:0]  av;
      logic [STATE_W-1:0] s;
      logic [STATE_W-1:0] nx;
      logic               q;
      av = ADDR_W'(a);
      s  = av[STATE_W-1:0];
      q  = av[ADDR_W-1];
      nx = s + (q ? STATE_W'(1) : STATE_W'(3));
      t[a] = {nx, ~nx[QSEL_W-1:0], s[CTRL_W-1:0] ^ {CTRL_W{q}}};
    end
    return t;
  endfunction
endpackage

// File: rtl/asm_phase_div.sv
module asm_phase_div #(
  parameter int DIV_LOG2 = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic lo_stb_o,
  output logic hi_stb_o,
  output logic sclk_h_o,
  output logic sclk_l_o
);
  localparam logic [DIV_LOG2-1:0] LAST = '1;
  localparam logic [DIV_LOG2-1:0] MID  = {1'b0, {(DIV_LOG2-1){1'b1}}};

  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign lo_stb_o = (cnt_q == LAST);
  assign hi_stb_o = (cnt_q == MID);
  assign sclk_h_o = ~cnt_q[DIV_LOG2-1];
  assign sclk_l_o = cnt_q[DIV_LOG2-1];
endmodule

// File: rtl/asm_qual_sel.sv
module asm_qual_sel #(
  parameter int SEL_W = 3,
  localparam int NIN  = 2 ** SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic [NIN-1:0]   cond_i,
  input  logic [SEL_W-1:0] sel_n_i,
  output logic             qual_o
);
  logic [SEL_W-1:0] idx;
  logic [NIN-1:0]   hit;
  logic             pick;
  logic             qual_q;

  assign idx = ~sel_n_i;

  for (genvar g = 0; g < NIN; g++) begin : g_dec
    assign hit[g] = cond_i[g] & (idx == SEL_W'(g));
  end

  assign pick = |hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    qual_q <= 1'b0;
    else if (smp_i) qual_q <= pick;
  end

  assign qual_o = qual_q;
endmodule

// File: rtl/asm_ucode_rom.sv
module asm_ucode_rom
  import asm_seq_pkg::*;
#(
  parameter ucode_t UCODE = default_ucode()
) (
  input  logic [ADDR_W-1:0] addr_i,
  output uword_t            word_o
);
  assign word_o = uword_t'(UCODE[addr_i]);
endmodule

// File: rtl/asm_seq.sv
module asm_seq
  import asm_seq_pkg::*;
#(
  parameter int     DIV_LOG2 = 5,
  parameter ucode_t UCODE    = default_ucode()
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NCOND-1:0]   cond_i,
  output logic               sclk_h_o,
  output logic               sclk_l_o,
  output logic [STATE_W-1:0] state_o,
  output logic               qual_o,
  output logic               oe_o,
  output logic               mem_out_o,
  output logic               xfer_en_o,
  output logic               close_sw_o
);
  logic               lo_stb, hi_stb;
  logic [STATE_W-1:0] state_q;
  logic [QSEL_W-1:0]  qsel_n_q;
  logic [CTRL_W-1:0]  ctrl_q;
  uword_t             word;

  asm_phase_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lo_stb_o (lo_stb),
    .hi_stb_o (hi_stb),
    .sclk_h_o (sclk_h_o),
    .sclk_l_o (sclk_l_o)
  );

  asm_qual_sel #(.SEL_W(QSEL_W)) u_qsel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .smp_i   (hi_stb),
    .cond_i  (cond_i),
    .sel_n_i (qsel_n_q),
    .qual_o  (qual_o)
  );

  asm_ucode_rom #(.UCODE(UCODE)) u_rom (
    .addr_i ({qual_o, state_q}),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= '0;
      qsel_n_q <= '1;
      ctrl_q   <= '0;
    end else if (lo_stb) begin
      state_q  <= word.nxt;
      qsel_n_q <= word.qsel_n;
      ctrl_q   <= {word.oe, word.mem_out, word.xfer_en, word.close_sw};
    end
  end

  assign state_o    = state_q;
  assign oe_o       = ctrl_q[3];
  assign mem_out_o  = ctrl_q[2];
  assign xfer_en_o  = ctrl_q[1];
  assign close_sw_o = ctrl_q[0];
endmodule

// File: rtl/asm_seq_chk.sv
module asm_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lo_stb,
  input logic       hi_stb,
  input logic [2:0] qsel_n,
  input logic [7:0] cond_i,
  input logic       sclk_h_o,
  input logic       sclk_l_o,
  input logic [6:0] state_o,
  input logic       qual_o,
  input logic [3:0] ctrl
);
  logic [2:0] sel_idx;
  assign sel_idx = ~qsel_n;

  assert_phase_compl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_h_o != sclk_l_o);

  assert_strobe_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lo_stb && hi_stb));

  assert_state_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_stb |=> $stable(state_o));

  assert_qual_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_stb |=> $stable(qual_o));

  assert_qual_pick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_stb |=> qual_o == $past(cond_i[sel_idx]));

  assert_ctrl_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_stb |=> $stable(ctrl));
endmodule

bind asm_seq asm_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .lo_stb   (lo_stb),
  .hi_stb   (hi_stb),
  .qsel_n   (qsel_n_q),
  .cond_i   (cond_i),
  .sclk_h_o (sclk_h_o),
  .sclk_l_o (sclk_l_o),
  .state_o  (state_o),
  .qual_o   (qual_o),
  .ctrl     ({oe_o, mem_out_o, xfer_en_o, close_sw_o})
);

// File: tb/asm_seq_tb.sv
module asm_seq_tb;
  localparam int PER  = 32;
  localparam int HALF = PER / 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] cond_i = '0;
  logic       sclk_h_o, sclk_l_o, qual_o, oe_o, mem_out_o, xfer_en_o, close_sw_o;
  logic [6:0] state_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  asm_seq u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cond_i     (cond_i),
    .sclk_h_o   (sclk_h_o),
    .sclk_l_o   (sclk_l_o),
    .state_o    (state_o),
    .qual_o     (qual_o),
    .oe_o       (oe_o),
    .mem_out_o  (mem_out_o),
    .xfer_en_o  (xfer_en_o),
    .close_sw_o (close_sw_o)
  );

  // reference model built from R2..R9
  int         m_cnt;
  logic [6:0] m_st;
  logic       m_q;
  logic [3:0] m_ctl;
  logic [2:0] m_idx;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt <= 0; m_st <= '0; m_q <= 1'b0; m_ctl <= '0; m_idx <= '0;
    end else begin
      logic [6:0] nx;
      if (m_cnt == HALF - 1) m_q <= cond_i[m_idx];            // R4 R5
      if (m_cnt == PER - 1) begin                               // R3 R6 R8 R9
        nx = m_st + (m_q ? 7'd1 : 7'd3);
        m_st  <= nx;
        m_idx <= nx[2:0];
        m_ctl <= m_st[3:0] ^ {4{m_q}};                          // R7
      end
      m_cnt <= (m_cnt + 1) % PER;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2 sclk_h", int'(sclk_h_o), int'(m_cnt < HALF));
    chk("R2 sclk_l", int'(sclk_l_o), int'(!(m_cnt < HALF)));
    chk("R6 state", int'(state_o), int'(m_st));
    chk("R5 qual", int'(qual_o), int'(m_q));
    chk("R7 ctrl", int'({oe_o, mem_out_o, xfer_en_o, close_sw_o}), int'(m_ctl));
  endtask

  task automatic check_reset();
    chk("R1 state", int'(state_o), 0);
    chk("R1 qual", int'(qual_o), 0);
    chk("R1 ctrl", int'({oe_o, mem_out_o, xfer_en_o, close_sw_o}), 0);
    chk("R1 sclk_h", int'(sclk_h_o), 1);
    chk("R1 sclk_l", int'(sclk_l_o), 0);
  endtask

  // one state period, cond either fixed or random on every fast cycle
  task automatic run_periods(input int n, input int mode, input logic [7:0] val);
    for (int i = 0; i < n * PER; i++) begin
      @(negedge clk_i);
      cmp_all();
      if (mode == 0) cond_i = val;
      else           cond_i = 8'($urandom);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_reset();                              // R1
    rst_ni = 1'b1;
    run_periods(40, 0, 8'h00);                  // q stays 0: step by 3 (R9)
    run_periods(40, 0, 8'hFF);                  // q stays 1: step by 1 (R9)
    run_periods(300, 0, 8'h5A);                 // fixed mixed pattern (R5)
    run_periods(1000, 1, 8'h00);                // R4: cond toggles between samples
    @(negedge clk_i);
    rst_ni = 1'b0;                              // mid-run reset
    @(negedge clk_i);
    check_reset();                              // R1
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_periods(200, 1, 8'h00);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule